// File: doc/BRIEF.md
# Speculative Output-Channel and Crossbar Slot Allocator

This block decides, every clock cycle, which router inputs may send a flit across the crossbar and, for flits that open a packet, which output virtual channel they take. Each input presents one request: a valid bit, a packet-start bit, the output port chosen by route computation and, for packet-start flits, the output virtual channel wanted on that port. The allocator answers in the same cycle with a per-input grant and, for granted packet-start flits, the index of the virtual channel won.

Channel allocation and crossbar-slot allocation run side by side rather than one after the other. The crossbar arbiter only needs the output port, so it does not wait for the channel result. A packet-start flit is granted only when it wins both. When it wins the port but loses its channel, the port slot for that cycle goes unused and the flit tries again later; no flit is dropped. Flits of packets that already own a channel are not speculative and beat packet-start flits to a port. Output channels that the credit tracker reports as busy never enter channel arbitration.

Each output port and each output channel has its own round-robin arbiter. The design has no state machine; its only state is the arbiters' priority pointers.

Top module: `spec_alloc`

## Requirements
- R1: After reset every arbiter pointer is at input 0, and with no valid request no grant is given.
- R2: An uncontended packet-start flit (`req_head`=1) is granted in the same cycle it requests. `grant_vc` bits [i*VW +: VW] then echo its requested channel index, and they are zero for any input that is not a granted packet-start flit.
- R3: At most one input is granted per output port per cycle. Input i's port is `req_port[i*PW +: PW]`.
- R4: When any continuing flit (`req_head`=0) requests a port, no packet-start flit is granted on that port in that cycle.
- R5: A packet-start flit is granted only if its output channel, at `ovc_busy` bit port*NVC+vc, is not busy and it won that channel's arbitration.
- R6: A packet-start flit that wins the port but loses its channel receives no grant, and no other input is granted on that port in that cycle. It is granted in a later cycle once its channel arbitration and port arbitration agree.
- R7: A port arbiter moves its pointer to one past its winner in every cycle in which it picks a winner, and it always picks one when any input requests its port.
- R8: A channel arbiter moves its pointer to one past its winner only when that winner is granted. Otherwise the pointer holds.
- R9: Only inputs with `req_valid`=1 are granted, and requests to different ports are granted together in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NIN | Request present on input i |
| req_head | input | NIN | 1: packet-start flit (speculative), 0: continuing flit |
| req_port | input | NIN*PW | Output port per input, field i at [i*PW +: PW] |
| req_vc | input | NIN*VW | Wanted output channel per input, field i at [i*VW +: VW] |
| ovc_busy | input | NOUT*NVC | Busy flag per output channel, bit port*NVC+vc |
| grant | output | NIN | Input i may traverse the crossbar this cycle |
| grant_vc | output | NIN*VW | Channel won by granted packet-start flit i, else 0 |

## Verification
The assertions assume that every port field is below NOUT and every channel field is below NVC. They also assume that requests and busy flags hold steady between clock edges. The bench only drives in-range indices. It changes the inputs at the falling edge and reads the grants one time unit later, before the next rising edge moves the pointers. Each scenario starts from reset, so the pointer positions it depends on are known.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
    // Next index in a cyclic order of n slots
    function automatic int wrap_inc(input int v, input int n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction
endpackage

// File: rtl/alloc_rr_arb.sv
module alloc_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    logic [IW-1:0] ptr_nx;

    always_comb begin
        gnt    = '0;
        ptr_nx = ptr;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (gnt == '0 && req[idx]) begin
                gnt[idx] = 1'b1;
                ptr_nx   = IW'(alloc_pkg::wrap_inc(idx, N));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else if (adv && |gnt) ptr <= ptr_nx;
    end

    assert_arb_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_arb_serve_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt));
    assert_arb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv && |gnt) |=> $stable(ptr));
endmodule

// File: rtl/alloc_port_stage.sv
module alloc_port_stage #(
    parameter int NIN  = 4,
    parameter int NOUT = 4,
    parameter int PW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIN-1:0]  valid,
    input  logic [NIN-1:0]  head,
    input  logic [NIN*PW-1:0] port,
    output logic [NIN-1:0]  won
);
    logic [NIN-1:0] pg [NOUT];

    for (genvar p = 0; p < NOUT; p++) begin : g_port
        logic [NIN-1:0] ns, sp, rq, g;
        always_comb begin
            for (int i = 0; i < NIN; i++) begin
                ns[i] = valid[i] && !head[i] && (port[i*PW +: PW] == PW'(p));
                sp[i] = valid[i] &&  head[i] && (port[i*PW +: PW] == PW'(p));
            end
            // continuing flits shut out speculative ones
            rq = (|ns) ? ns : sp;
        end
        alloc_rr_arb #(.N(NIN)) u_arb (
            .clk(clk), .rst_n(rst_n), .req(rq), .adv(1'b1), .gnt(g)
        );
        assign pg[p] = g;
    end

    always_comb begin
        won = '0;
        for (int p = 0; p < NOUT; p++) won = won | pg[p];
    end
endmodule

// File: rtl/alloc_vc_stage.sv
module alloc_vc_stage #(
    parameter int NIN  = 4,
    parameter int NOUT = 4,
    parameter int NVC  = 2,
    parameter int PW   = 2,
    parameter int VW   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NIN-1:0]     valid,
    input  logic [NIN-1:0]     head,
    input  logic [NIN*PW-1:0]  port,
    input  logic [NIN*VW-1:0]  vc,
    input  logic [NOUT*NVC-1:0] busy,
    input  logic [NIN-1:0]     used,
    output logic [NIN-1:0]     vc_ok
);
    localparam int NO = NOUT * NVC;

    logic [NIN-1:0] vg [NO];

    for (genvar o = 0; o < NO; o++) begin : g_ovc
        localparam int P = o / NVC;
        localparam int V = o % NVC;
        logic [NIN-1:0] rq, g;
        always_comb begin
            for (int i = 0; i < NIN; i++)
                rq[i] = valid[i] && head[i] && !busy[o]
                        && (port[i*PW +: PW] == PW'(P))
                        && (vc[i*VW +: VW] == VW'(V));
        end
        alloc_rr_arb #(.N(NIN)) u_arb (
            .clk(clk), .rst_n(rst_n), .req(rq), .adv(|(g & used)), .gnt(g)
        );
        assign vg[o] = g;
    end

    always_comb begin
        vc_ok = '0;
        for (int o = 0; o < NO; o++) vc_ok = vc_ok | vg[o];
    end
endmodule

// File: rtl/spec_alloc.sv
module spec_alloc #(
    parameter int NIN  = 4,
    parameter int NOUT = 4,
    parameter int NVC  = 2,
    parameter int PW   = (NOUT > 1) ? $clog2(NOUT) : 1,
    parameter int VW   = (NVC > 1) ? $clog2(NVC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NIN-1:0]      req_valid,
    input  logic [NIN-1:0]      req_head,
    input  logic [NIN*PW-1:0]   req_port,
    input  logic [NIN*VW-1:0]   req_vc,
    input  logic [NOUT*NVC-1:0] ovc_busy,
    output logic [NIN-1:0]      grant,
    output logic [NIN*VW-1:0]   grant_vc
);
    logic [NIN-1:0] port_won;
    logic [NIN-1:0] vc_won;

    alloc_port_stage #(.NIN(NIN), .NOUT(NOUT), .PW(PW)) u_sa (
        .clk(clk), .rst_n(rst_n), .valid(req_valid), .head(req_head),
        .port(req_port), .won(port_won)
    );

    alloc_vc_stage #(.NIN(NIN), .NOUT(NOUT), .NVC(NVC), .PW(PW), .VW(VW)) u_va (
        .clk(clk), .rst_n(rst_n), .valid(req_valid), .head(req_head),
        .port(req_port), .vc(req_vc), .busy(ovc_busy), .used(grant),
        .vc_ok(vc_won)
    );

    always_comb begin
        for (int i = 0; i < NIN; i++) begin
            grant[i] = port_won[i] && (!req_head[i] || vc_won[i]);
            grant_vc[i*VW +: VW] = (grant[i] && req_head[i]) ? req_vc[i*VW +: VW] : '0;
        end
    end

    for (genvar p = 0; p < NOUT; p++) begin : g_chk
        logic [NIN-1:0] onp;
        always_comb
            for (int i = 0; i < NIN; i++) onp[i] = (req_port[i*PW +: PW] == PW'(p));
        assert_one_per_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant & onp));
        assert_cont_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (|(req_valid & ~req_head & onp)) |-> ((grant & req_head & onp) == '0));
    end

    for (genvar i = 0; i < NIN; i++) begin : g_in
        assert_free_vc_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && req_head[i]) |->
            !ovc_busy[int'(req_port[i*PW +: PW]) * NVC + int'(req_vc[i*VW +: VW])]);
        assert_valid_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> req_valid[i]);
    end
endmodule

// File: tb/spec_alloc_tb.sv
module spec_alloc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NIN = 4, NOUT = 4, NVC = 2, PW = 2, VW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NIN-1:0] req_valid = '0, req_head = '0;
    logic [NIN*PW-1:0] req_port = '0;
    logic [NIN*VW-1:0] req_vc = '0;
    logic [NOUT*NVC-1:0] ovc_busy = '0;
    logic [NIN-1:0] grant;
    logic [NIN*VW-1:0] grant_vc;

    int total = 0, bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_alloc #(.NIN(NIN), .NOUT(NOUT), .NVC(NVC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_head(req_head),
        .req_port(req_port), .req_vc(req_vc), .ovc_busy(ovc_busy),
        .grant(grant), .grant_vc(grant_vc)
    );

    task automatic check(input string tag, input logic [NIN-1:0] eg, input logic [NIN-1:0] ev);
        total++;
        if (grant !== eg || grant_vc !== ev) begin
            bad++;
            $display("FAIL %s: grant=%b grant_vc=%b expected grant=%b grant_vc=%b",
                     tag, grant, grant_vc, eg, ev);
        end
    endtask

    task automatic clear_req();
        req_valid = '0; req_head = '0; req_port = '0; req_vc = '0; ovc_busy = '0;
    endtask

    task automatic put(input int i, input bit h, input int p, input int v);
        req_valid[i] = 1'b1;
        req_head[i]  = h;
        req_port[i*PW +: PW] = PW'(p);
        req_vc[i*VW +: VW]   = VW'(v);
    endtask

    // inputs change at the falling edge; results read 1 unit later
    task automatic next_cycle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clear_req();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_idle();
        do_reset();
        #1 check("R1 idle after reset", 4'b0000, 4'b0000);
        next_cycle();
        req_head = 4'b1111; req_port = 8'b11100100; req_vc = 4'b1010;
        #1 check("R9 fields set but not valid", 4'b0000, 4'b0000);
    endtask

    task automatic t_single_head();
        do_reset();
        put(0, 1, 1, 0);
        #1 check("R2 lone head granted same cycle", 4'b0001, 4'b0000);
    endtask

    task automatic t_cont_priority();
        do_reset();
        put(0, 1, 2, 1);
        put(1, 0, 2, 0);
        #1 check("R4 continuing flit beats head", 4'b0010, 4'b0000);
    endtask

    task automatic t_busy_vc();
        do_reset();
        put(0, 1, 1, 1);
        ovc_busy[1*NVC + 1] = 1'b1;
        #1 check("R5 busy channel blocks head", 4'b0000, 4'b0000);
        next_cycle();
        ovc_busy = '0;
        #1 check("R5/R2 channel freed, head granted with vc 1", 4'b0001, 4'b0001);
    endtask

    task automatic t_port_rr();
        do_reset();
        put(0, 0, 3, 0);
        put(2, 0, 3, 0);
        #1 check("R7 round robin first pick input 0", 4'b0001, 4'b0000);
        next_cycle();
        #1 check("R7 round robin second pick input 2", 4'b0100, 4'b0000);
        next_cycle();
        #1 check("R7 round robin wraps to input 0", 4'b0001, 4'b0000);
    endtask

    task automatic t_wasted_slot();
        do_reset();
        put(0, 0, 3, 0);
        #1 check("R7 setup body on port 3", 4'b0001, 4'b0000);
        next_cycle();
        clear_req();
        put(0, 1, 3, 0);
        put(1, 1, 3, 0);
        #1 check("R6 port and channel winners differ, slot unused", 4'b0000, 4'b0000);
        next_cycle();
        #1 check("R6/R8 retry succeeds, channel pointer held", 4'b0001, 4'b0000);
        next_cycle();
        req_valid[0] = 1'b0;
        #1 check("R8 channel pointer moved after use", 4'b0010, 4'b0000);
    endtask

    task automatic t_parallel();
        do_reset();
        put(0, 0, 0, 0);
        put(1, 0, 1, 0);
        put(2, 1, 2, 1);
        put(3, 1, 3, 0);
        #1 check("R9 four ports granted together", 4'b1111, 4'b0100);
    endtask

    task automatic t_two_heads_one_port();
        do_reset();
        put(0, 1, 1, 0);
        put(1, 1, 1, 1);
        #1 check("R3 two heads one port, one grant", 4'b0001, 4'b0000);
        next_cycle();
        req_valid[0] = 1'b0;
        #1 check("R3 second head granted next, vc 1", 4'b0010, 4'b0010);
    endtask

    initial begin
        t_reset_idle();
        t_single_head();
        t_cont_priority();
        t_busy_vc();
        t_port_rr();
        t_wasted_slot();
        t_parallel();
        t_two_heads_one_port();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule